// File: doc/BRIEF.md
# Windowed Modulo Address Generator

This block steps through a two-level index space and emits one physical memory address per step for a single array that lives in a shared on-chip memory. The array is stored in place: instead of giving every element its own word, the linear storage-order value `COEF_OUT*x + COEF_IN*y` is folded into a circular window of `WIN` words. The window sits at word `BASE`. Other arrays can then use the rest of the same memory. With the default parameters, `x` counts 0..9 and `y` counts 0..19, the coefficients are 20 and 2, and a 78-word window sits at word 134 of a 334-word memory. The 200 addresses all fall in 134..211.

The consumer pulses `start` while the block is idle. The block then offers addresses with a valid/ready handshake. The inner index `y` moves fastest. The block holds each address and its indices until the consumer accepts them. One cycle after the final address is taken, `done` pulses and the block goes back to idle. The modulo is kept incrementally and no divider is built, so each coefficient must be smaller than the window. The same block covers small layouts as well. Two examples are a 5x5 array walked with the outer index from 1 to 4 in row-major order with a window of 6, and the same array in column-major order with a window of 21.

Control is a three-state machine:
- **ST_IDLE** waits. The transition *launch* (start seen) loads the first indices and terms and moves to ST_RUN.
- **ST_RUN** drives `valid`. The transition *step* (accept, not last) advances the indices and terms and stays in ST_RUN. The transition *finish* (accept of the last element) moves to ST_DONE.
- **ST_DONE** drives `done` for one cycle. The transition *retire* returns to ST_IDLE unconditionally.

Top module: `wmod_addr_gen`

## Requirements
- R1: After reset, and while idle with no start, `valid` and `done` are 0.
- R2: A start in idle makes `valid` 1 on the next cycle. The address is then `BASE + (COEF_OUT*OUT_LO + COEF_IN*IN_LO) mod WIN`, with `idx_out`=OUT_LO and `idx_in`=IN_LO.
- R3: Every offered address equals `BASE + ((COEF_OUT*idx_out + COEF_IN*idx_in) mod WIN)`.
- R4: Elements come in nested order. `idx_in` runs IN_LO..IN_HI for each `idx_out` value, and `idx_out` runs OUT_LO..OUT_HI.
- R5: While `valid`=1 and `ready`=0, the address and both indices hold their values. They advance only on a cycle where `valid` and `ready` are both 1.
- R6: Every offered address lies in BASE..BASE+WIN-1.
- R7: Exactly (OUT_HI-OUT_LO+1)*(IN_HI-IN_LO+1) elements are offered per run, 200 with the defaults. `done` stays 0 until the last one is accepted.
- R8: `done` is 1 for exactly one cycle, the cycle after the final accept. `valid` is 0 in that cycle, and the block is idle afterwards.
- R9: `start` has no effect while a run is active or while `done` is high. The sequence continues unchanged, and no new run begins after `done`.
- R10: The parameter sets for a 5x5 array with outer range 1..4 (coefficients 5/1 with window 6, and 1/5 with window 21) produce addresses that follow R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (honoured only in ST_IDLE) |
| ready | input | 1 | Consumer accepts the offered address |
| valid | output | 1 | An address is offered |
| addr | output | $clog2(MEM_WORDS) | Physical word address |
| idx_out | output | $clog2(OUT_HI+2) | Current outer index |
| idx_in | output | $clog2(IN_HI+2) | Current inner index |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Two events can fall in the same cycle. One is the inner index wrapping, which rebuilds the running remainder from the outer term. The other is the outer term itself crossing the window edge. A further collision is a stray `start` arriving during a stall or during the `done` cycle. The bench provokes both. It streams all elements under three ready patterns (always ready, every other cycle, and two of three), so that inner wraps and window folds land on both stalled and accepted cycles. It also pokes `start` mid-run and during `done`. Each offered element is compared with an address the bench computes from the plain modulo formula, and the cycle after `done` must show no new run.

// File: rtl/wmag_pkg.sv
package wmag_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } wmag_state_e;

    // One modular addition for operands that are already below the window.
    function automatic int unsigned wrap_add(input int unsigned a,
                                             input int unsigned b,
                                             input int unsigned win);
        int unsigned s;
        s = a + b;
        return (s >= win) ? (s - win) : s;
    endfunction

endpackage

// File: rtl/wmag_ctrl.sv
module wmag_ctrl
    import wmag_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        fire,
    input  logic        last,
    output wmag_state_e state,
    output logic        valid,
    output logic        done,
    output logic        load
);

    wmag_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (start)        state_d = ST_RUN;   // launch
            ST_RUN:  if (fire && last) state_d = ST_DONE;  // finish
            ST_DONE:                   state_d = ST_IDLE;  // retire
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        valid = 1'b0;
        done  = 1'b0;
        load  = 1'b0;
        unique case (state)
            ST_IDLE: load  = start;
            ST_RUN:  valid = 1'b1;
            ST_DONE: done  = 1'b1;
            default: ;
        endcase
    end

    AST_LAUNCH_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> valid); // R2
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && fire && last) |=> (done && !valid)); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !valid)); // R8
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !(fire && last)) |=> (valid && !done)); // R9

endmodule

// File: rtl/wmag_idx.sv
module wmag_idx #(
    parameter int unsigned LO = 0,
    parameter int unsigned HI = 9,
    parameter int unsigned W  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] val,
    output logic         at_hi
);

    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    assign at_hi = (val == HI_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val <= LO_V;
        end else if (load) begin
            val <= LO_V;
        end else if (step) begin
            val <= at_hi ? LO_V : (val + W'(1));
        end
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (val >= LO_V) && (val <= HI_V)); // R4

endmodule

// File: rtl/wmag_term.sv
module wmag_term
    import wmag_pkg::*;
#(
    parameter int unsigned COEF_OUT = 20,
    parameter int unsigned COEF_IN  = 2,
    parameter int unsigned WIN      = 78,
    parameter int unsigned INIT_X   = 0,
    parameter int unsigned INIT_Y   = 0,
    parameter int unsigned RW       = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          wrap_in,
    output logic [RW-1:0] rem
);

    localparam int unsigned INIT_RUN = (INIT_X + INIT_Y) % WIN;

    logic [RW-1:0] tx_q;
    logic [RW-1:0] tx_next;
    logic [RW-1:0] run_next_in;
    logic [RW-1:0] run_next_wrap;

    // Outer term advanced by its coefficient, folded once
    assign tx_next       = RW'(wrap_add(int'(tx_q), COEF_OUT, WIN));
    // Inner step of the running remainder
    assign run_next_in   = RW'(wrap_add(int'(rem), COEF_IN, WIN));
    // Remainder rebuilt from the new outer term when the inner index wraps
    assign run_next_wrap = RW'(wrap_add(int'(tx_next), INIT_Y, WIN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rem  <= '0;
        end else if (load) begin
            tx_q <= RW'(INIT_X);
            rem  <= RW'(INIT_RUN);
        end else if (step) begin
            if (wrap_in) begin
                tx_q <= tx_next;
                rem  <= run_next_wrap;
            end else begin
                rem  <= run_next_in;
            end
        end
    end

    AST_REM_BELOW_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rem) < WIN); // R3
    AST_OUTER_BELOW_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_q) < WIN); // R3

endmodule

// File: rtl/wmod_addr_gen.sv
module wmod_addr_gen
    import wmag_pkg::*;
#(
    parameter int unsigned MEM_WORDS = 334,
    parameter int unsigned OUT_LO    = 0,
    parameter int unsigned OUT_HI    = 9,
    parameter int unsigned IN_LO     = 0,
    parameter int unsigned IN_HI     = 19,
    parameter int unsigned COEF_OUT  = 20,
    parameter int unsigned COEF_IN   = 2,
    parameter int unsigned WIN       = 78,
    parameter int unsigned BASE      = 134,
    localparam int unsigned AW       = $clog2(MEM_WORDS),
    localparam int unsigned XW       = $clog2(OUT_HI + 2),
    localparam int unsigned YW       = $clog2(IN_HI + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ready,
    output logic          valid,
    output logic [AW-1:0] addr,
    output logic [XW-1:0] idx_out,
    output logic [YW-1:0] idx_in,
    output logic          done
);

    localparam int unsigned RW     = $clog2(WIN + 1);
    localparam int unsigned INIT_X = (COEF_OUT * OUT_LO) % WIN;
    localparam int unsigned INIT_Y = (COEF_IN * IN_LO) % WIN;
    localparam logic [AW-1:0] BASE_A = AW'(BASE);

    wmag_state_e   state;
    logic          load;
    logic          fire;
    logic          x_hi;
    logic          y_hi;
    logic          last;
    logic [RW-1:0] rem;

    assign fire = valid & ready;
    assign last = x_hi & y_hi;

    wmag_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .fire  (fire),
        .last  (last),
        .state (state),
        .valid (valid),
        .done  (done),
        .load  (load)
    );

    wmag_idx #(.LO(IN_LO), .HI(IN_HI), .W(YW)) u_idx_in (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (fire),
        .val   (idx_in),
        .at_hi (y_hi)
    );

    wmag_idx #(.LO(OUT_LO), .HI(OUT_HI), .W(XW)) u_idx_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (fire & y_hi),
        .val   (idx_out),
        .at_hi (x_hi)
    );

    wmag_term #(
        .COEF_OUT (COEF_OUT),
        .COEF_IN  (COEF_IN),
        .WIN      (WIN),
        .INIT_X   (INIT_X),
        .INIT_Y   (INIT_Y),
        .RW       (RW)
    ) u_term (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (fire),
        .wrap_in (y_hi),
        .rem     (rem)
    );

    assign addr = BASE_A + AW'(rem);

    AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (int'(addr) >= BASE) && (int'(addr) < BASE + WIN)); // R6
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(addr) && $stable(idx_out) && $stable(idx_in))); // R5
    AST_FIRST_ELEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (int'(idx_out) == OUT_LO) && (int'(idx_in) == IN_LO)); // R2
    AST_DONE_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !valid); // R8

endmodule

// File: tb/wmod_addr_gen_test.sv
module wmod_addr_gen_test;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    logic start_v [3];
    logic ready_v [3];

    logic       v0, d0; logic [8:0] a0; logic [3:0] x0; logic [4:0] y0;
    logic       v1, d1; logic [8:0] a1; logic [2:0] x1; logic [2:0] y1;
    logic       v2, d2; logic [8:0] a2; logic [2:0] x2; logic [2:0] y2;

    wmod_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start_v[0]), .ready(ready_v[0]),
        .valid(v0), .addr(a0), .idx_out(x0), .idx_in(y0), .done(d0));

    wmod_addr_gen #(.OUT_LO(1), .OUT_HI(4), .IN_LO(0), .IN_HI(4),
                    .COEF_OUT(5), .COEF_IN(1), .WIN(6), .BASE(10)) uut_row (
        .clk(clk), .rst_n(rst_n), .start(start_v[1]), .ready(ready_v[1]),
        .valid(v1), .addr(a1), .idx_out(x1), .idx_in(y1), .done(d1));

    wmod_addr_gen #(.OUT_LO(1), .OUT_HI(4), .IN_LO(0), .IN_HI(4),
                    .COEF_OUT(1), .COEF_IN(5), .WIN(21), .BASE(100)) uut_col (
        .clk(clk), .rst_n(rst_n), .start(start_v[2]), .ready(ready_v[2]),
        .valid(v2), .addr(a2), .idx_out(x2), .idx_in(y2), .done(d2));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic observe(input int sel, output int v, output int a,
                           output int xi, output int yi, output int d);
        case (sel)
            0: begin v = v0; a = a0; xi = x0; yi = y0; d = d0; end
            1: begin v = v1; a = a1; xi = x1; yi = y1; d = d1; end
            default: begin v = v2; a = a2; xi = x2; yi = y2; d = d2; end
        endcase
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // One complete run; mode picks the ready pattern, poke adds stray starts.
    task automatic run_frame(input int sel, input int xlo, input int xhi,
                             input int ylo, input int yhi, input int cx,
                             input int cy, input int win, input int base,
                             input int mode, input bit poke, input string tag);
        int cyc = 0;
        int v, a, xi, yi, d;
        @(negedge clk);
        start_v[sel] = 1'b1;
        ready_v[sel] = 1'b0;
        @(posedge clk);
        for (int x = xlo; x <= xhi; x++) begin
            for (int y = ylo; y <= yhi; y++) begin
                bit taken = 0;
                while (!taken) begin
                    int exp;
                    bit r;
                    @(negedge clk);
                    start_v[sel] = poke && (cyc % 5 == 2);   // R9 stray start
                    observe(sel, v, a, xi, yi, d);
                    exp = base + ((cx * x + cy * y) % win);
                    if (x == xlo && y == ylo && cyc == 0)
                        check(v == 1 && a == exp, "R2", {tag, " first element"}, a, exp);
                    check(v == 1, "R7", {tag, " valid during run"}, v, 1);
                    check(a == exp, "R3", {tag, " address"}, a, exp);
                    check(a >= base && a < base + win, "R6", {tag, " window"}, a, base);
                    check(xi == x && yi == y, "R4", {tag, " indices"}, xi * 100 + yi, x * 100 + y);
                    check(d == 0, "R7", {tag, " early done"}, d, 0);
                    if (sel == 0 && mode != 0)
                        check(a == exp, "R5", {tag, " held across stall"}, a, exp);
                    case (mode)
                        0: r = 1'b1;
                        1: r = (cyc % 2) == 1;
                        default: r = (cyc % 3) != 1;
                    endcase
                    ready_v[sel] = r;
                    cyc++;
                    @(posedge clk);
                    taken = r;
                end
            end
        end
        @(negedge clk);
        ready_v[sel] = 1'b0;
        start_v[sel] = poke;            // start during done must be ignored
        observe(sel, v, a, xi, yi, d);
        check(d == 1, "R8", {tag, " done pulse"}, d, 1);
        check(v == 0, "R8", {tag, " no valid with done"}, v, 0);
        @(negedge clk);
        start_v[sel] = 1'b0;
        observe(sel, v, a, xi, yi, d);
        check(d == 0, "R8", {tag, " done single cycle"}, d, 0);
        check(v == 0, "R9", {tag, " no restart after done"}, v, 0);
        @(negedge clk);
        observe(sel, v, a, xi, yi, d);
        check(v == 0 && d == 0, "R8", {tag, " back to idle"}, v + d, 0);
    endtask

    task automatic t_reset_idle();
        int v, a, xi, yi, d;
        for (int s = 0; s < 3; s++) begin
            observe(s, v, a, xi, yi, d);
            check(v == 0 && d == 0, "R1", "reset outputs", v + d, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 3; s++) ready_v[s] = 1'b1;
        repeat (4) @(negedge clk);
        for (int s = 0; s < 3; s++) begin
            observe(s, v, a, xi, yi, d);
            check(v == 0 && d == 0, "R1", "idle without start", v + d, 0);
            ready_v[s] = 1'b0;
        end
    endtask

    initial begin
        for (int s = 0; s < 3; s++) begin
            start_v[s] = 1'b0;
            ready_v[s] = 1'b0;
        end
        repeat (3) @(negedge clk);
        t_reset_idle();
        run_frame(0, 0, 9, 0, 19, 20, 2, 78, 134, 0, 0, "default stream");
        run_frame(0, 0, 9, 0, 19, 20, 2, 78, 134, 1, 1, "default stall R5 R9");
        run_frame(0, 0, 9, 0, 19, 20, 2, 78, 134, 2, 0, "default uneven ready");
        run_frame(1, 1, 4, 0, 4, 5, 1, 6, 10, 2, 0, "row-major R10");
        run_frame(2, 1, 4, 0, 4, 1, 5, 21, 100, 1, 1, "column-major R10");
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule